// File: doc/BRIEF.md
# Sprite Collision Detector

This block watches the sprite layer one pixel at a time and records which sprites have touched each other and which have touched the playfield foreground. On every pixel-enable cycle it receives one bit per sprite saying whether that sprite has an opaque pixel at the current beam position, a per-sprite enable mask, and the two-bit playfield pixel code together with a flag saying whether the playfield is in a multicolour mode. It keeps two sticky per-sprite collision registers: one for sprite-to-sprite contact and one for sprite-to-foreground contact. The block does not care where the beam is, so contact in the borders is recorded like contact in the visible area.

Software reads either register through a small read port. A read returns the register's contents one cycle later and empties that register. Each register is tracked by a two-state machine. `ACC_EMPTY` means the register holds zero. `ACC_HELD` means at least one bit is set. The transitions are:
- `T_HIT` (`ACC_EMPTY` to `ACC_HELD`): the first contact.
- `T_ACCUM` (`ACC_HELD` to `ACC_HELD`, no read): further contacts are ORed in.
- `T_DRAIN` (`ACC_HELD` to `ACC_EMPTY`): a read with no contact in the same cycle.
- `T_RELOAD` (`ACC_HELD` to `ACC_HELD`): a read that coincides with a contact.

A one-cycle event strobe goes to the interrupt controller on `T_HIT` and on `T_RELOAD`.

Top module: `sprite_collide`

## Requirements
- R1: After reset both collision registers are zero, `rd_data` is zero and both event strobes are low.
- R2: On a pixel-enable cycle where two or more enabled sprites are opaque, the bit of every such sprite is ORed into the sprite-sprite register. A lone opaque sprite sets nothing there.
- R3: On a pixel-enable cycle where the playfield pixel is foreground, the bit of every enabled opaque sprite is ORed into the sprite-foreground register.
- R4: Foreground decode. With `pf_multi`=0 the pixel is foreground exactly when `pf_code[0]`=1. With `pf_multi`=1 the pixel is foreground exactly when `pf_code[1]`=1, so codes 10 and 11 are foreground and codes 00 and 01 are not.
- R5: A sprite whose `spr_enable` bit is 0, or whose `spr_opaque` bit is 0, neither sets a bit nor counts toward the two-sprite threshold.
- R6: A pulse on `rd_en` selects a register with `rd_sel`: 0 selects sprite-sprite and 1 selects sprite-foreground. In the next cycle `rd_data` holds that register's value from before the read, and the register becomes zero. The other register is unchanged, and `rd_data` holds its value between reads.
- R7: Collision bits accumulate by OR across cycles until the register is read.
- R8: `ss_event` or `sf_event` is high for exactly one cycle, the cycle after the edge at which its register goes from zero to nonzero. Further contacts while the register is nonzero and unread give no strobe.
- R9: When a read of a register and a new contact for that register happen in the same cycle, the register's next value is exactly the new contact bits, and its event strobe fires.
- R10: When `pix_en` is low, the sprite and playfield inputs have no effect on either register or strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_en | input | 1 | Pixel enable; inputs are sampled when high |
| spr_opaque | input | NUM_SPR | Per-sprite opaque pixel at current position |
| spr_enable | input | NUM_SPR | Per-sprite enable mask |
| pf_code | input | 2 | Playfield pixel code |
| pf_multi | input | 1 | Playfield multicolour mode |
| rd_en | input | 1 | Read strobe (clears the selected register) |
| rd_sel | input | 1 | 0 = sprite-sprite, 1 = sprite-foreground |
| rd_data | output | NUM_SPR | Registered read data |
| ss_event | output | 1 | Sprite-sprite interrupt event strobe |
| sf_event | output | 1 | Sprite-foreground interrupt event strobe |

## Verification
The hardest situation to reach is `T_RELOAD`, where a read and a fresh contact land on the same clock edge. Normal software reads never line up with a collision pixel like this. The bench makes it happen with one cycle that drives `rd_en` together with a pixel-enable carrying a new sprite pair. It then checks three things: the returned value is the old contents, the strobe fires again, and a follow-up read returns only the new bits. A table of single-pixel patterns covers the foreground decode in both playfield modes and the enable masking. Directed sequences then cover accumulation without re-strobing, selective clearing, and idle pixel cycles.

// File: rtl/scd_pkg.sv
package scd_pkg;

    // occupancy of one collision register
    typedef enum logic {
        ACC_EMPTY = 1'b0,
        ACC_HELD  = 1'b1
    } acc_state_e;

    // register indices on the read port
    localparam int SEL_SS   = 0;
    localparam int SEL_SF   = 1;
    localparam int NUM_REGS = 2;

    // minimum number of touching sprites for a sprite-sprite contact
    localparam int MIN_PAIR = 2;

endpackage

// File: rtl/scd_fg_qualify.sv
module scd_fg_qualify #(
    parameter int PF_BITS = 2
) (
    input  logic [PF_BITS-1:0] pf_code,
    input  logic               pf_multi,
    output logic               fg
);

    // hires: the single pixel bit is the lsb
    // multicolour: only the two upper codes are foreground, 01 is background
    always_comb begin
        if (pf_multi) begin
            fg = pf_code[PF_BITS-1];
        end else begin
            fg = pf_code[0];
        end
    end

endmodule

// File: rtl/scd_hit_detect.sv
module scd_hit_detect
    import scd_pkg::*;
#(
    parameter int NUM_SPR = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [NUM_SPR-1:0] opaque,
    input  logic [NUM_SPR-1:0] enable,
    input  logic               fg,
    output logic [NUM_SPR-1:0] ss_hit,
    output logic [NUM_SPR-1:0] sf_hit
);

    localparam int CNT_W = $clog2(NUM_SPR + 1);

    logic [NUM_SPR-1:0] live;
    logic [CNT_W-1:0]   live_cnt;

    always_comb begin
        live = en ? (opaque & enable) : '0;
        live_cnt = '0;
        for (int i = 0; i < NUM_SPR; i++) begin
            live_cnt = live_cnt + CNT_W'(live[i]);
        end
        ss_hit = (int'(live_cnt) >= MIN_PAIR) ? live : '0;
        sf_hit = fg ? live : '0;
    end

    // R2: a sprite-sprite contact always involves at least two sprites
    a_r2_pair_min: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_hit != '0) |-> ($countones(ss_hit) >= MIN_PAIR));

    // R5: disabled sprites never appear in any hit vector
    a_r5_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (((ss_hit | sf_hit) & ~enable) == '0));

    // R10: idle pixel cycles produce no hits
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> ((ss_hit == '0) && (sf_hit == '0)));

endmodule

// File: rtl/scd_accum.sv
module scd_accum
    import scd_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] hit_i,
    input  logic             clr_i,
    output logic [WIDTH-1:0] acc_o,
    output logic             ev_o
);

    acc_state_e       state_q, state_d;
    logic [WIDTH-1:0] acc_q, acc_d;
    logic             ev_q, fire;
    logic             hit_any;

    assign hit_any = |hit_i;

    // next state: T_HIT, T_ACCUM, T_DRAIN, T_RELOAD
    always_comb begin
        state_d = state_q;
        fire    = 1'b0;
        unique case (state_q)
            ACC_EMPTY: begin
                if (hit_any) begin          // T_HIT
                    state_d = ACC_HELD;
                    fire    = 1'b1;
                end
            end
            ACC_HELD: begin
                if (clr_i) begin
                    if (hit_any) begin      // T_RELOAD
                        state_d = ACC_HELD;
                        fire    = 1'b1;
                    end else begin          // T_DRAIN
                        state_d = ACC_EMPTY;
                    end
                end else begin              // T_ACCUM
                    state_d = ACC_HELD;
                end
            end
        endcase
    end

    // register contents: a read discards the old bits but keeps this cycle's hits
    always_comb begin
        acc_d = clr_i ? hit_i : (acc_q | hit_i);
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ACC_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            ev_q  <= 1'b0;
        end else begin
            acc_q <= acc_d;
            ev_q  <= fire;
        end
    end

    assign acc_o = acc_q;
    assign ev_o  = ev_q;

    // R8: the state tracks register occupancy
    a_r8_state_tracks_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ACC_EMPTY) == (acc_q == '0));

    // R8: a strobe is only seen with a nonzero register
    a_r8_event_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        ev_q |-> (acc_q != '0));

    // R8: no strobe while an unread nonzero register collects more bits
    a_r8_no_restrobe: assert property (@(posedge clk) disable iff (!rst_n)
        ((acc_q != '0) && !clr_i) |=> !ev_q);

    // R7: without a read, no bit is ever lost
    a_r7_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((acc_q & $past(acc_q)) == $past(acc_q)));

    // R6: a read with no coincident hit empties the register
    a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && (hit_i == '0)) |=> (acc_q == '0));

    // R9: a read with a coincident hit keeps exactly the new hit and strobes
    a_r9_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && (hit_i != '0)) |=> ((acc_q == $past(hit_i)) && ev_q));

endmodule

// File: rtl/sprite_collide.sv
module sprite_collide
    import scd_pkg::*;
#(
    parameter int NUM_SPR = 8,
    parameter int PF_BITS = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pix_en,
    input  logic [NUM_SPR-1:0] spr_opaque,
    input  logic [NUM_SPR-1:0] spr_enable,
    input  logic [PF_BITS-1:0] pf_code,
    input  logic               pf_multi,
    input  logic               rd_en,
    input  logic               rd_sel,
    output logic [NUM_SPR-1:0] rd_data,
    output logic               ss_event,
    output logic               sf_event
);

    logic               fg;
    logic [NUM_SPR-1:0] hit   [NUM_REGS];
    logic [NUM_SPR-1:0] acc   [NUM_REGS];
    logic [NUM_REGS-1:0] ev;
    logic [NUM_REGS-1:0] clr;
    logic [NUM_SPR-1:0] rd_q;

    scd_fg_qualify #(.PF_BITS(PF_BITS)) u_fg (
        .pf_code  (pf_code),
        .pf_multi (pf_multi),
        .fg       (fg)
    );

    scd_hit_detect #(.NUM_SPR(NUM_SPR)) u_hit (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (pix_en),
        .opaque (spr_opaque),
        .enable (spr_enable),
        .fg     (fg),
        .ss_hit (hit[SEL_SS]),
        .sf_hit (hit[SEL_SF])
    );

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        assign clr[g] = rd_en && (int'(rd_sel) == g);

        scd_accum #(.WIDTH(NUM_SPR)) u_acc (
            .clk   (clk),
            .rst_n (rst_n),
            .hit_i (hit[g]),
            .clr_i (clr[g]),
            .acc_o (acc[g]),
            .ev_o  (ev[g])
        );
    end

    // registered read port: returns contents from before the clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (rd_en) begin
            rd_q <= rd_sel ? acc[SEL_SF] : acc[SEL_SS];
        end
    end

    assign rd_data  = rd_q;
    assign ss_event = ev[SEL_SS];
    assign sf_event = ev[SEL_SF];

    // R6: the unselected register is untouched by a read when no hit arrives
    a_r6_other_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_sel && (hit[SEL_SF] == '0)) |=> (acc[SEL_SF] == $past(acc[SEL_SF])));

    // R6: read data returns the pre-clear contents
    a_r6_read_value: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_sel) |=> (rd_data == $past(acc[SEL_SF])));

endmodule

// File: tb/sprite_collide_tb.sv
`timescale 1ns/1ps
module sprite_collide_tb;

    localparam int NS = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pix_en = 1'b0;
    logic [NS-1:0] spr_opaque = '0;
    logic [NS-1:0] spr_enable = '0;
    logic [1:0]    pf_code = '0;
    logic          pf_multi = 1'b0;
    logic          rd_en = 1'b0;
    logic          rd_sel = 1'b0;
    logic [NS-1:0] rd_data;
    logic          ss_event, sf_event;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    sprite_collide #(.NUM_SPR(NS), .PF_BITS(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .pix_en(pix_en),
        .spr_opaque(spr_opaque), .spr_enable(spr_enable),
        .pf_code(pf_code), .pf_multi(pf_multi),
        .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
        .ss_event(ss_event), .sf_event(sf_event)
    );

    typedef struct packed {
        logic [7:0] opq;
        logic [7:0] ena;
        logic [1:0] code;
        logic       multi;
        logic [7:0] ess;
        logic [7:0] esf;
    } vec_t;

    // single-pixel patterns starting from empty registers (R2 R3 R4 R5)
    localparam vec_t VEC [0:9] = '{
        '{8'h03, 8'hFF, 2'b00, 1'b0, 8'h03, 8'h00},
        '{8'h01, 8'hFF, 2'b01, 1'b0, 8'h00, 8'h01},
        '{8'h81, 8'h01, 2'b00, 1'b0, 8'h00, 8'h00},
        '{8'h0F, 8'hFF, 2'b01, 1'b1, 8'h0F, 8'h00},
        '{8'h10, 8'hFF, 2'b10, 1'b1, 8'h00, 8'h10},
        '{8'h24, 8'hFF, 2'b11, 1'b1, 8'h24, 8'h24},
        '{8'h00, 8'hFF, 2'b11, 1'b0, 8'h00, 8'h00},
        '{8'hFF, 8'h00, 2'b01, 1'b0, 8'h00, 8'h00},
        '{8'hC0, 8'hFF, 2'b10, 1'b0, 8'hC0, 8'h00},
        '{8'h80, 8'hF0, 2'b01, 1'b0, 8'h00, 8'h80}
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one cycle of stimulus from a negedge to the next negedge
    task automatic cyc(input logic pe, input logic [7:0] opq, input logic [7:0] ena,
                       input logic [1:0] code, input logic multi,
                       input logic rd, input logic sel);
        pix_en = pe; spr_opaque = opq; spr_enable = ena;
        pf_code = code; pf_multi = multi; rd_en = rd; rd_sel = sel;
        @(negedge clk);
        pix_en = 1'b0; rd_en = 1'b0; spr_opaque = '0;
    endtask

    task automatic rd(input logic sel);
        cyc(1'b0, 8'h00, 8'h00, 2'b00, 1'b0, 1'b1, sel);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 rd_data", rd_data, 8'h00);
        check("R1 ss_event", {7'd0, ss_event}, 8'h00);
        check("R1 sf_event", {7'd0, sf_event}, 8'h00);
        rd(1'b0);
        check("R1 ss reg", rd_data, 8'h00);
        rd(1'b1);
        check("R1 sf reg", rd_data, 8'h00);

        // table walk
        for (int i = 0; i < 10; i++) begin
            cyc(1'b1, VEC[i].opq, VEC[i].ena, VEC[i].code, VEC[i].multi, 1'b0, 1'b0);
            check("R8 ss_event vec", {7'd0, ss_event}, {7'd0, VEC[i].ess != 8'h00});
            check("R8 sf_event vec", {7'd0, sf_event}, {7'd0, VEC[i].esf != 8'h00});
            rd(1'b0);
            check("R2 R5 ss vec", rd_data, VEC[i].ess);
            rd(1'b1);
            check("R3 R4 sf vec", rd_data, VEC[i].esf);
        end

        // R7 R8: accumulation without re-strobe
        cyc(1'b1, 8'h03, 8'hFF, 2'b00, 1'b0, 1'b0, 1'b0);
        check("R8 first strobe", {7'd0, ss_event}, 8'h01);
        cyc(1'b0, 8'h00, 8'hFF, 2'b00, 1'b0, 1'b0, 1'b0);
        check("R8 strobe one cycle", {7'd0, ss_event}, 8'h00);
        cyc(1'b1, 8'h0C, 8'hFF, 2'b00, 1'b0, 1'b0, 1'b0);
        check("R8 no restrobe", {7'd0, ss_event}, 8'h00);
        rd(1'b0);
        check("R7 accumulated", rd_data, 8'h0F);
        rd(1'b0);
        check("R6 cleared after read", rd_data, 8'h00);

        // R10: inputs ignored with pix_en low
        cyc(1'b0, 8'hFF, 8'hFF, 2'b11, 1'b0, 1'b0, 1'b0);
        check("R10 no ss_event", {7'd0, ss_event}, 8'h00);
        check("R10 no sf_event", {7'd0, sf_event}, 8'h00);
        rd(1'b0);
        check("R10 ss untouched", rd_data, 8'h00);
        rd(1'b1);
        check("R10 sf untouched", rd_data, 8'h00);

        // R9: read and new hit on the same edge
        cyc(1'b1, 8'h03, 8'hFF, 2'b00, 1'b0, 1'b0, 1'b0);
        cyc(1'b1, 8'h30, 8'hFF, 2'b00, 1'b0, 1'b1, 1'b0);
        check("R9 old value returned", rd_data, 8'h03);
        check("R9 strobe again", {7'd0, ss_event}, 8'h01);
        rd(1'b0);
        check("R9 only new bits", rd_data, 8'h30);

        // R6: a read clears only the selected register; rd_data holds
        cyc(1'b1, 8'h03, 8'hFF, 2'b01, 1'b0, 1'b0, 1'b0);
        rd(1'b1);
        check("R6 sf read", rd_data, 8'h03);
        cyc(1'b0, 8'h00, 8'h00, 2'b00, 1'b0, 1'b0, 1'b0);
        check("R6 rd_data holds", rd_data, 8'h03);
        rd(1'b0);
        check("R6 ss kept", rd_data, 8'h03);
        rd(1'b1);
        check("R6 sf cleared", rd_data, 8'h00);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule